// File: doc/BRIEF.md
# Multimode Clock, Countdown Timer and Stopwatch Core

This core keeps time for a display front end. One register set holds the time of day, a second holds a countdown timer and a third holds a stopwatch. The mode register picks which of them appears on the output fields, and the core also gives the colour for that mode. The time of day is shown in 12-hour or 24-hour form. A millisecond tick enable advances all three counters. Single-cycle button pulses cycle the mode, toggle an edit flag, bump the hour or minute, and zero the counter that is on display. Two level switches run the timer and the stopwatch.

The counters run whatever mode is selected. The time of day advances on every tick, and the timer and stopwatch advance whenever their switch is on. The increment buttons obey a different rule in each mode. In a clock mode they need the edit flag. In timer mode the timer must be paused. In stopwatch mode they do nothing. Every output comes from registers through logic only, so a change made at a clock edge shows on the ports right after that same edge.

Top module: `mc_clock_core`

## Requirements
- R1: `mode_o` resets to 0 and steps 0 (12-hour), 1 (24-hour), 2 (timer), 3 (stopwatch), then back to 0, once for each `mode_btn_i` pulse.
- R2: The millisecond field counts 0..999 and carries into seconds (0..59), minutes (0..59) and hours. The time of day rolls over from 23:59:59.999 to 00:00:00.000.
- R3: `edit_btn_i` toggles `edit_o` (reset 0). In modes 0 and 1 with `edit_o` set, `hour_btn_i` adds one to the time-of-day hour (23 wraps to 0) and `min_btn_i` adds one to its minute (59 wraps to 0, no carry into the hour). Otherwise the clock ignores them.
- R4: In mode 2 with `tmr_run_i` low, the hour and minute buttons add one to the timer hour (99 wraps to 0) and minute (59 wraps to 0). With `tmr_run_i` high they have no effect.
- R5: While `tmr_run_i` is high, each tick takes one millisecond off the timer, with borrows. At zero the timer holds zero.
- R6: While `sw_run_i` is high, each tick adds one millisecond to the stopwatch, and its hour wraps from 99 to 0. While the switch is low the stopwatch holds. The increment buttons never change it.
- R7: `clr_btn_i` zeros only the counter that the current mode displays. The time of day is that counter in modes 0 and 1.
- R8: In mode 0 the hour shows as 12 for hour 0 and as hour-12 for hours 13..23. `pm_o` is 1 for hours 12..23. In every other mode the hour shows unchanged and `pm_o` is 0.
- R9: `rgb_o` is 12'h90F in mode 0, 12'hFF0 in mode 1, 12'hF00 in mode 2 and 12'h0F0 in mode 3.
- R10: The counters keep running in every mode: the time of day ticks always, even during edit. Within one counter in one cycle, clear beats an increment and an increment beats the tick, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Millisecond tick enable |
| mode_btn_i | input | 1 | Mode step pulse |
| edit_btn_i | input | 1 | Edit flag toggle pulse |
| hour_btn_i | input | 1 | Hour increment pulse |
| min_btn_i | input | 1 | Minute increment pulse |
| clr_btn_i | input | 1 | Zero the displayed counter |
| tmr_run_i | input | 1 | Timer run switch |
| sw_run_i | input | 1 | Stopwatch run switch |
| hours_o | output | 7 | Displayed hours |
| minutes_o | output | 6 | Displayed minutes |
| seconds_o | output | 6 | Displayed seconds |
| millis_o | output | 10 | Displayed milliseconds |
| pm_o | output | 1 | Afternoon flag in 12-hour mode |
| mode_o | output | 2 | Current mode |
| edit_o | output | 1 | Edit flag |
| rgb_o | output | 12 | Mode colour, 4 bits per channel |

## Verification
Every result is due one edge after its stimulus. A tick, button pulse or switch level that is present at a rising edge changes the registers at that edge, and the output logic passes the change straight to the ports. The bench sets its inputs at the falling edge and updates its own model of all three counters at the next rising edge. It compares the ports at the falling edge after that, half a period clear of either event. The long directed runs (timer to zero, clock rollover) advance the model on every tick and compare only once the run ends.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned HOUR_W = 7;
  localparam int unsigned MIN_W  = 6;
  localparam int unsigned SEC_W  = 6;
  localparam int unsigned MS_W   = 10;
  localparam int unsigned MS_TOP = 999;
  localparam int unsigned MS_SEC_TOP = 59;
  localparam int unsigned RGB_W  = 12;

  typedef enum logic [1:0] {
    MODE_H12 = 2'd0,
    MODE_H24 = 2'd1,
    MODE_TMR = 2'd2,
    MODE_SW  = 2'd3
  } mode_e;

  typedef struct packed {
    logic [HOUR_W-1:0] hr;
    logic [MIN_W-1:0]  mn;
    logic [SEC_W-1:0]  sc;
    logic [MS_W-1:0]   ms;
  } time_t;

  function automatic logic [RGB_W-1:0] mode_rgb(input mode_e m);
    case (m)
      MODE_H12: return 12'h90F;
      MODE_H24: return 12'hFF0;
      MODE_TMR: return 12'hF00;
      default:  return 12'h0F0;
    endcase
  endfunction
endpackage

// File: rtl/mc_mode_ctrl.sv
module mc_mode_ctrl
  import mc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode_btn_i,
  input  logic  edit_btn_i,
  output mode_e mode_o,
  output logic  edit_o
);
  mode_e mode_q;
  logic  edit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_H12;
      edit_q <= 1'b0;
    end else begin
      if (mode_btn_i) mode_q <= mode_e'(mode_q + 2'd1);
      if (edit_btn_i) edit_q <= ~edit_q;
    end
  end

  assign mode_o = mode_q;
  assign edit_o = edit_q;

  a_r1_mode_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_btn_i |=> mode_q == mode_e'($past(mode_q) + 2'd1));
  a_r1_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_btn_i |=> $stable(mode_q));
  a_r3_edit_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edit_btn_i |=> edit_q != $past(edit_q));
endmodule

// File: rtl/mc_time_counter.sv
module mc_time_counter
  import mc_pkg::*;
#(
  parameter int unsigned HOUR_MOD   = 24,
  parameter bit          COUNT_DOWN = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  step_i,
  input  logic  hour_inc_i,
  input  logic  min_inc_i,
  output time_t cnt_o
);
  localparam logic [HOUR_W-1:0] HOUR_TOP = HOUR_W'(HOUR_MOD - 1);
  localparam logic [MIN_W-1:0]  MIN_TOP  = MIN_W'(MS_SEC_TOP);
  localparam logic [SEC_W-1:0]  SEC_TOP  = SEC_W'(MS_SEC_TOP);
  localparam logic [MS_W-1:0]   MSEC_TOP = MS_W'(MS_TOP);

  time_t cnt_q, cnt_d, stepped, bumped;
  logic  bump;

  assign bump = hour_inc_i | min_inc_i;

  generate
    if (COUNT_DOWN) begin : g_down
      always_comb begin
        stepped = cnt_q;
        if (cnt_q != '0) begin
          if (cnt_q.ms != '0) stepped.ms = cnt_q.ms - 1'b1;
          else begin
            stepped.ms = MSEC_TOP;
            if (cnt_q.sc != '0) stepped.sc = cnt_q.sc - 1'b1;
            else begin
              stepped.sc = SEC_TOP;
              if (cnt_q.mn != '0) stepped.mn = cnt_q.mn - 1'b1;
              else begin
                stepped.mn = MIN_TOP;
                stepped.hr = cnt_q.hr - 1'b1;
              end
            end
          end
        end
      end
    end else begin : g_up
      always_comb begin
        stepped = cnt_q;
        if (cnt_q.ms != MSEC_TOP) stepped.ms = cnt_q.ms + 1'b1;
        else begin
          stepped.ms = '0;
          if (cnt_q.sc != SEC_TOP) stepped.sc = cnt_q.sc + 1'b1;
          else begin
            stepped.sc = '0;
            if (cnt_q.mn != MIN_TOP) stepped.mn = cnt_q.mn + 1'b1;
            else begin
              stepped.mn = '0;
              stepped.hr = (cnt_q.hr == HOUR_TOP) ? '0 : cnt_q.hr + 1'b1;
            end
          end
        end
      end
    end
  endgenerate

  always_comb begin
    bumped = cnt_q;
    if (hour_inc_i) bumped.hr = (cnt_q.hr == HOUR_TOP) ? '0 : cnt_q.hr + 1'b1;
    if (min_inc_i)  bumped.mn = (cnt_q.mn == MIN_TOP)  ? '0 : cnt_q.mn + 1'b1;
  end

  // priority: clear, then increment, then tick
  always_comb begin
    if (clear_i)     cnt_d = '0;
    else if (bump)   cnt_d = bumped;
    else if (step_i) cnt_d = stepped;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_ms_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q.ms <= MSEC_TOP && cnt_q.sc <= SEC_TOP && cnt_q.mn <= MIN_TOP);
  a_r2_hour_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q.hr <= HOUR_TOP);
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !bump && !step_i |=> $stable(cnt_q));
  a_r3_min_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_inc_i && !hour_inc_i && !clear_i |=> $stable(cnt_q.hr));
  a_r7_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);

  generate
    if (COUNT_DOWN) begin : g_floor_chk
      a_r5_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q == '0 && !bump |=> cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/mc_view.sv
module mc_view
  import mc_pkg::*;
(
  input  mode_e             mode_i,
  input  time_t             tod_i,
  input  time_t             tmr_i,
  input  time_t             sw_i,
  output time_t             shown_o,
  output logic              pm_o,
  output logic [RGB_W-1:0]  rgb_o
);
  localparam logic [HOUR_W-1:0] NOON = HOUR_W'(12);

  time_t sel;

  always_comb begin
    unique case (mode_i)
      MODE_TMR: sel = tmr_i;
      MODE_SW:  sel = sw_i;
      default:  sel = tod_i;
    endcase
  end

  always_comb begin
    shown_o = sel;
    pm_o    = 1'b0;
    if (mode_i == MODE_H12) begin
      pm_o = sel.hr >= NOON;
      if (sel.hr == '0)       shown_o.hr = NOON;
      else if (sel.hr > NOON) shown_o.hr = sel.hr - NOON;
    end
  end

  assign rgb_o = mode_rgb(mode_i);
endmodule

// File: rtl/mc_clock_core.sv
module mc_clock_core
  import mc_pkg::*;
#(
  parameter int unsigned DAY_HOURS = 24,
  parameter int unsigned AUX_HOURS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode_btn_i,
  input  logic              edit_btn_i,
  input  logic              hour_btn_i,
  input  logic              min_btn_i,
  input  logic              clr_btn_i,
  input  logic              tmr_run_i,
  input  logic              sw_run_i,
  output logic [HOUR_W-1:0] hours_o,
  output logic [MIN_W-1:0]  minutes_o,
  output logic [SEC_W-1:0]  seconds_o,
  output logic [MS_W-1:0]   millis_o,
  output logic              pm_o,
  output logic [1:0]        mode_o,
  output logic              edit_o,
  output logic [RGB_W-1:0]  rgb_o
);
  mode_e mode;
  logic  edit;
  logic  in_clock, tod_set, tmr_set;
  time_t tod, tmr, sw, shown;

  mc_mode_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_btn_i (mode_btn_i),
    .edit_btn_i (edit_btn_i),
    .mode_o     (mode),
    .edit_o     (edit)
  );

  assign in_clock = (mode == MODE_H12) || (mode == MODE_H24);
  assign tod_set  = in_clock && edit;
  assign tmr_set  = (mode == MODE_TMR) && !tmr_run_i;

  mc_time_counter #(.HOUR_MOD(DAY_HOURS), .COUNT_DOWN(1'b0)) i_tod (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clr_btn_i && in_clock),
    .step_i     (tick_i),
    .hour_inc_i (hour_btn_i && tod_set),
    .min_inc_i  (min_btn_i && tod_set),
    .cnt_o      (tod)
  );

  mc_time_counter #(.HOUR_MOD(AUX_HOURS), .COUNT_DOWN(1'b1)) i_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clr_btn_i && (mode == MODE_TMR)),
    .step_i     (tick_i && tmr_run_i),
    .hour_inc_i (hour_btn_i && tmr_set),
    .min_inc_i  (min_btn_i && tmr_set),
    .cnt_o      (tmr)
  );

  mc_time_counter #(.HOUR_MOD(AUX_HOURS), .COUNT_DOWN(1'b0)) i_sw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clr_btn_i && (mode == MODE_SW)),
    .step_i     (tick_i && sw_run_i),
    .hour_inc_i (1'b0),
    .min_inc_i  (1'b0),
    .cnt_o      (sw)
  );

  mc_view i_view (
    .mode_i  (mode),
    .tod_i   (tod),
    .tmr_i   (tmr),
    .sw_i    (sw),
    .shown_o (shown),
    .pm_o    (pm_o),
    .rgb_o   (rgb_o)
  );

  assign hours_o   = shown.hr;
  assign minutes_o = shown.mn;
  assign seconds_o = shown.sc;
  assign millis_o  = shown.ms;
  assign mode_o    = mode;
  assign edit_o    = edit;

  a_r8_hour12_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd0 |-> (hours_o >= 7'd1 && hours_o <= 7'd12));
  a_r8_pm_clock_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd0 |-> !pm_o);
  a_r6_sw_ignores_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_run_i && !(clr_btn_i && mode == MODE_SW) |=> $stable(sw));
  a_r4_tmr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_run_i && !tick_i && !(clr_btn_i && mode == MODE_TMR) |=> $stable(tmr));
  a_r10_tod_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !clr_btn_i && !hour_btn_i && !min_btn_i |=> tod != $past(tod));
endmodule

// File: tb/test_mc_clock_core.sv
module test_mc_clock_core;
  localparam time CLK_PERIOD = 10ns;
  localparam longint HOUR_MS = 3600000;
  localparam longint MIN_MS  = 60000;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, mode_b = 0, edit_b = 0, hour_b = 0, min_b = 0, clr_b = 0;
  logic tmr_run = 0, sw_run = 0;
  logic [6:0] hours; logic [5:0] minutes, seconds; logic [9:0] millis;
  logic pm, edit; logic [1:0] mode; logic [11:0] rgb;

  int checks = 0, fails = 0, cycles = 0;
  int m_mode = 0; bit m_edit = 0;
  longint m_tod = 0, m_tmr = 0, m_sw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_clock_core i_mc_clock_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_btn_i(mode_b),
    .edit_btn_i(edit_b), .hour_btn_i(hour_b), .min_btn_i(min_b),
    .clr_btn_i(clr_b), .tmr_run_i(tmr_run), .sw_run_i(sw_run),
    .hours_o(hours), .minutes_o(minutes), .seconds_o(seconds), .millis_o(millis),
    .pm_o(pm), .mode_o(mode), .edit_o(edit), .rgb_o(rgb)
  );

  function automatic longint inc_hr(longint t, int hmod);
    longint h = t / HOUR_MS;
    return t - h * HOUR_MS + ((h + 1) % hmod) * HOUR_MS;
  endfunction

  function automatic longint inc_mn(longint t);
    longint m = (t / MIN_MS) % 60;
    return t - m * MIN_MS + ((m + 1) % 60) * MIN_MS;
  endfunction

  function automatic longint next_cnt(longint t, bit clr, bit hi, bit mi,
                                      bit stp, bit down, int hmod);
    longint r = t;
    if (clr) return 0;
    if (hi || mi) begin
      if (hi) r = inc_hr(r, hmod);
      if (mi) r = inc_mn(r);
      return r;
    end
    if (stp) begin
      if (down) return (t == 0) ? 0 : t - 1;
      return (t + 1) % (hmod * HOUR_MS);
    end
    return t;
  endfunction

  function automatic logic [11:0] exp_rgb(int md);
    case (md)
      0: return 12'h90F;
      1: return 12'hFF0;
      2: return 12'hF00;
      default: return 12'h0F0;
    endcase
  endfunction

  task automatic model_step();
    bit clk_mode = (m_mode <= 1);
    bit tod_set  = clk_mode && m_edit;
    bit tmr_set  = (m_mode == 2) && !tmr_run;
    m_tod = next_cnt(m_tod, clr_b && clk_mode, hour_b && tod_set, min_b && tod_set, tick, 0, 24);
    m_tmr = next_cnt(m_tmr, clr_b && m_mode == 2, hour_b && tmr_set, min_b && tmr_set,
                     tick && tmr_run, 1, 100);
    m_sw  = next_cnt(m_sw, clr_b && m_mode == 3, 0, 0, tick && sw_run, 0, 100);
    if (mode_b) m_mode = (m_mode + 1) % 4;
    if (edit_b) m_edit = !m_edit;
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    longint t = (m_mode == 2) ? m_tmr : (m_mode == 3) ? m_sw : m_tod;
    longint h = t / HOUR_MS;
    longint eh = h;
    bit epm = 0;
    if (m_mode == 0) begin
      epm = (h >= 12);
      eh = (h == 0) ? 12 : (h > 12) ? h - 12 : h;
    end
    chk("R1", "mode", mode, m_mode);
    chk("R3", "edit", edit, m_edit);
    chk("R9", "rgb", rgb, exp_rgb(m_mode));
    chk("R8", "pm", pm, epm);
    chk(req, "hours", hours, eh);
    chk(req, "minutes", minutes, (t / MIN_MS) % 60);
    chk(req, "seconds", seconds, (t / 1000) % 60);
    chk(req, "millis", millis, t % 1000);
  endtask

  task automatic cyc(bit do_chk, string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (do_chk) compare(req);
    mode_b = 0; edit_b = 0; hour_b = 0; min_b = 0; clr_b = 0;
  endtask

  task automatic press_n(ref logic b, input int n, input string req);
    for (int i = 0; i < n; i++) begin b = 1; cyc(1, req); end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++; fails++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");                              // reset state

    press_n(mode_b, 4, "R1");                   // R1/R9 full mode cycle
    press_n(hour_b, 2, "R3");                   // edit off: ignored
    edit_b = 1; cyc(1, "R3");
    press_n(hour_b, 13, "R3");                  // hour 13
    compare("R8");                              // 12h shows 1 PM
    press_n(mode_b, 1, "R8");                   // 24h shows 13
    press_n(hour_b, 11, "R3");                  // 23 -> 0 wrap at 11th
    press_n(min_b, 61, "R3");                   // 59 -> 0, no hour carry
    press_n(mode_b, 3, "R8");                   // back to 12h, hour 0 -> 12
    tick = 1; cyc(1, "R10"); cyc(1, "R10");     // tod ticks during edit
    hour_b = 1; cyc(1, "R10");                  // increment beats tick
    tick = 0;

    // R4: timer set while paused, locked while running
    press_n(mode_b, 2, "R4");
    press_n(min_b, 1, "R4");
    tmr_run = 1;
    press_n(hour_b, 2, "R4");
    press_n(min_b, 2, "R4");
    // R5: run down to zero and hold
    tick = 1;
    for (int i = 0; i < 60010; i++) cyc(0, "R5");
    compare("R5");
    cyc(1, "R5");
    tick = 0; tmr_run = 0;
    press_n(hour_b, 101, "R4");                 // timer hour wraps 99 -> 0

    // R6: stopwatch runs, ignores increments, holds when off
    press_n(mode_b, 1, "R6");
    sw_run = 1; tick = 1;
    for (int i = 0; i < 1500; i++) cyc(i % 100 == 0, "R6");
    hour_b = 1; min_b = 1; cyc(1, "R6");
    sw_run = 0; cyc(1, "R6"); cyc(1, "R6");
    clr_b = 1; cyc(1, "R7");                    // only stopwatch zeroed
    tick = 0;
    press_n(mode_b, 1, "R7");

    // R2: time of day rolls over
    clr_b = 1; cyc(1, "R7");
    press_n(hour_b, 23, "R2");
    press_n(min_b, 59, "R2");
    press_n(mode_b, 1, "R2");
    tick = 1;
    for (int i = 0; i < 59999; i++) cyc(0, "R2");
    compare("R2");
    cyc(1, "R2");
    cyc(1, "R2");
    tick = 0;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      tick   = ($urandom % 2) == 0;
      mode_b = ($urandom % 25) == 0;
      edit_b = ($urandom % 30) == 0;
      hour_b = ($urandom % 12) == 0;
      min_b  = ($urandom % 12) == 0;
      clr_b  = ($urandom % 200) == 0;
      if (($urandom % 60) == 0) tmr_run = !tmr_run;
      if (($urandom % 60) == 0) sw_run = !sw_run;
      cyc(1, "R10");
    end
    finish_run();
  end
endmodule